// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Access Translator

This block turns a single memory-mapped bus access into a complete serial flash transaction on one of several chip selects. An accepted access produces, on one continuous chip-select window, an opcode byte, a programmable number of address bytes, an optional run of dummy clocks and then a 16-bit data phase. Reads may collect their data over one, two or four input lines. Writes always shift their data out on the single output line.

Every chip select owns a setup word. The word holds its own read and write opcodes, its address width, its dummy length (counted either in whole bytes or in single bits) and its read lane mode. The setup word is captured when an access is accepted, so a later rewrite cannot disturb a transaction already in flight. A control word holds two bits. One hands the shared serial engine to this translator. The other decides whether completed accesses raise a word-complete interrupt pulse. While the translator does not own the engine, every access is refused with an error response and the serial lines stay quiet.

Top module: `mmflash_xlate`

## Requirements
- R1: After reset every setup word holds read opcode 0x03, write opcode 0x02, three address bytes, no dummy clocks and single-lane reads. The control word is zero, so the translator does not own the engine and interrupts are off. All chip selects are high, the serial clock is low and no response is pending.
- R2: The setup word layout is: bits [7:0] read opcode, [15:8] write opcode, [17:16] address byte count minus one, [19:18] dummy byte count, [24:20] dummy bit count, [26:25] read lane mode. A transaction first sends the opcode and then the low N address bytes, both MSB first on the output line. Each bit takes one low clock period followed by one high clock period of the serial clock, and the serial clock is never high for two cycles in a row.
- R3: When the dummy byte count is nonzero, 8 times its value dummy clocks follow the address. When it is zero, the 5-bit dummy bit count gives the number of dummy clocks, and 0 means none. The output line is driven low during dummy clocks.
- R4: Lane modes 0 and 2 read 16 bits over 16 clocks on input line 1, MSB first. The first byte received lands in read data [15:8] and the second in [7:0].
- R5: Lane mode 1 reads in 8 clocks. Input line 0 carries the even (first) byte, which lands in read data [15:8], and input line 1 carries the odd byte, which lands in [7:0]. Both are MSB first.
- R6: Lane mode 3 reads in 4 clocks, one nibble per clock on input lines 3..0, with line 3 as the most significant bit. The upper read data byte arrives first.
- R7: A write sends the write opcode, the address and the dummy clocks, then the 16 write data bits MSB first on the output line. The output enable stays high throughout.
- R8: Only the chip select named by the access goes low. It stays low from the first opcode clock through the last data clock. All chip selects are high in the cycle before the done pulse and during it, and the serial clock is low whenever no chip select is active.
- R9: An access made while control bit 0 is 0 gets a one-cycle done pulse together with an error flag in the next cycle. The serial clock and the chip selects do not toggle, and the owner output shows control bit 0.
- R10: Control bit 1 gates the word-complete interrupt. The interrupt pulses with done on a successful access only when the bit is 1 in the done cycle, and it never pulses with an error.
- R11: Each chip select uses only its own setup word. Writing one setup word leaves the transactions of the other chip selects unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 2 | Bit 0 translator owns engine, bit 1 interrupt enable |
| setup_we | input | 1 | Setup word write strobe |
| setup_idx | input | CS_W | Chip select whose setup word is written |
| setup_wdata | input | 27 | Setup word value |
| bus_req | input | 1 | One-cycle access request, honoured when idle |
| bus_we | input | 1 | 1 for write access, 0 for read |
| bus_cs | input | CS_W | Target chip select |
| bus_addr | input | 32 | Flash address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with done |
| bus_done | output | 1 | One-cycle response pulse |
| bus_err | output | 1 | Error flag accompanying done |
| word_irq | output | 1 | Word-complete interrupt pulse |
| xlate_owns | output | 1 | High when the translator owns the serial engine |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_d0 | output | 1 | Output data line |
| spi_d0_oe | output | 1 | Output enable for the output data line |
| spi_din | input | 4 | Input data lines 3..0 |

## Verification
The interrupt decision and a write of the control word can fall into the same clock. The done pulse is registered at the edge that follows the cycle in which the chip selects return high, and a control write issued in that same cycle takes effect at that same edge. The bench detects the chip-select release from the pins and issues its enable change exactly then, in both directions. It expects the interrupt to follow the newly written value, because the gate samples the enable in the done cycle itself.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 16;
    localparam int SETUP_W = 27;
    localparam int CNT_W   = 5;

    typedef struct packed {
        logic [1:0] lane_mode;
        logic [4:0] dmy_bits;
        logic [1:0] dmy_bytes;
        logic [1:0] addr_nm1;
        logic [7:0] wr_op;
        logic [7:0] rd_op;
    } cs_setup_t;

    localparam cs_setup_t SETUP_RST = '{
        lane_mode: 2'd0, dmy_bits: 5'd0, dmy_bytes: 2'd0,
        addr_nm1: 2'd2, wr_op: 8'h02, rd_op: 8'h03};

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_END
    } phase_e;

    typedef enum logic [1:0] {LN_ONE, LN_TWO, LN_FOUR} lanes_e;

    function automatic lanes_e decode_lanes(input logic [1:0] mode);
        case (mode)
            2'd1:    return LN_TWO;
            2'd3:    return LN_FOUR;
            default: return LN_ONE;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] dummy_len(input logic [1:0] nbytes,
                                                  input logic [4:0] nbits);
        return (nbytes != 2'd0) ? {nbytes, 3'b000} : nbits;
    endfunction

endpackage

// File: rtl/mmx_setup_bank.sv
module mmx_setup_bank
    import mmx_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [CS_W-1:0]    idx,
    input  logic [SETUP_W-1:0] wdata,
    input  logic [CS_W-1:0]    rd_idx,
    output cs_setup_t          rd_setup
);
    cs_setup_t bank [NUM_CS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CS; i++) begin
            if (rst)
                bank[i] <= SETUP_RST;
            else if (we && idx == CS_W'(i))
                bank[i] <= cs_setup_t'(wdata);
        end
    end

    assign rd_setup = bank[rd_idx];
endmodule

// File: rtl/mmx_rx_gather.sv
module mmx_rx_gather
    import mmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take,
    input  lanes_e            lanes,
    input  logic [3:0]        din,
    output logic [WORD_W-1:0] word
);
    localparam int HALF = WORD_W / 2;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word <= '0;
        end else if (take) begin
            case (lanes)
                LN_TWO:  word <= {word[WORD_W-2:HALF], din[0],
                                  word[HALF-2:0], din[1]};
                LN_FOUR: word <= {word[WORD_W-5:0], din};
                default: word <= {word[WORD_W-2:0], din[1]};
            endcase
        end
    end
endmodule

// File: rtl/mmx_seq.sv
module mmx_seq
    import mmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  cs_setup_t         setup,
    output logic              busy,
    output logic              done,
    output logic              cs_act,
    output logic              sclk,
    output logic              d0,
    output logic              d0_oe,
    output logic              rx_take,
    output logic              rx_clr,
    output lanes_e            lanes
);
    phase_e            ph;
    logic              half;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] osh;
    cs_setup_t         s_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wd_q;
    logic              done_q;

    logic              active, step;
    logic [CNT_W-1:0]  dlen, data_cnt;
    logic [ADDR_W-1:0] data_load;

    always_comb begin
        active    = (ph == PH_CMD) || (ph == PH_ADDR) ||
                    (ph == PH_DUMMY) || (ph == PH_DATA);
        step      = active && half;
        lanes     = decode_lanes(s_q.lane_mode);
        dlen      = dummy_len(s_q.dmy_bytes, s_q.dmy_bits);
        data_load = we_q ? {wd_q, {(ADDR_W-WORD_W){1'b0}}} : '0;
        if (we_q)
            data_cnt = CNT_W'(WORD_W - 1);
        else if (lanes == LN_TWO)
            data_cnt = CNT_W'(WORD_W/2 - 1);
        else if (lanes == LN_FOUR)
            data_cnt = CNT_W'(WORD_W/4 - 1);
        else
            data_cnt = CNT_W'(WORD_W - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            half   <= 1'b0;
            cnt    <= '0;
            osh    <= '0;
            s_q    <= SETUP_RST;
            we_q   <= 1'b0;
            addr_q <= '0;
            wd_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        s_q    <= setup;
                        we_q   <= req_we;
                        addr_q <= req_addr;
                        wd_q   <= req_wdata;
                        osh    <= {(req_we ? setup.wr_op : setup.rd_op),
                                   {(ADDR_W-8){1'b0}}};
                        cnt    <= CNT_W'(7);
                        half   <= 1'b0;
                        ph     <= PH_CMD;
                    end
                end
                PH_END: begin
                    ph     <= PH_IDLE;
                    done_q <= 1'b1;
                end
                default: begin
                    half <= ~half;
                    if (half) begin
                        osh <= {osh[ADDR_W-2:0], 1'b0};
                        if (cnt != '0) begin
                            cnt <= cnt - CNT_W'(1);
                        end else begin
                            case (ph)
                                PH_CMD: begin
                                    ph  <= PH_ADDR;
                                    osh <= addr_q << {~s_q.addr_nm1, 3'b000};
                                    cnt <= {s_q.addr_nm1, 3'b111};
                                end
                                PH_ADDR: begin
                                    if (dlen != '0) begin
                                        ph  <= PH_DUMMY;
                                        osh <= '0;
                                        cnt <= dlen - CNT_W'(1);
                                    end else begin
                                        ph  <= PH_DATA;
                                        osh <= data_load;
                                        cnt <= data_cnt;
                                    end
                                end
                                PH_DUMMY: begin
                                    ph  <= PH_DATA;
                                    osh <= data_load;
                                    cnt <= data_cnt;
                                end
                                default: begin
                                    ph  <= PH_END;
                                    osh <= '0;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    assign busy    = (ph != PH_IDLE);
    assign done    = done_q;
    assign cs_act  = active;
    assign sclk    = step;
    assign d0      = active && osh[ADDR_W-1];
    assign d0_oe   = active && !((ph == PH_DATA) && !we_q);
    assign rx_take = step && (ph == PH_DATA) && !we_q;
    assign rx_clr  = start && (ph == PH_IDLE);
endmodule

// File: rtl/mmflash_xlate.sv
module mmflash_xlate
    import mmx_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_we,
    input  logic [1:0]         ctl_wdata,
    input  logic               setup_we,
    input  logic [CS_W-1:0]    setup_idx,
    input  logic [SETUP_W-1:0] setup_wdata,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [CS_W-1:0]    bus_cs,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               bus_done,
    output logic               bus_err,
    output logic               word_irq,
    output logic               xlate_owns,
    output logic               spi_sclk,
    output logic [NUM_CS-1:0]  spi_cs_n,
    output logic               spi_d0,
    output logic               spi_d0_oe,
    input  logic [3:0]         spi_din
);
    logic            sel_q, irq_en_q, err_q;
    logic [CS_W-1:0] cs_q;
    logic            seq_busy, seq_done, cs_act, rx_take, rx_clr;
    logic            accept, reject;
    cs_setup_t       cur_setup;
    lanes_e          lanes;

    assign accept = bus_req && !seq_busy && sel_q;
    assign reject = bus_req && !seq_busy && !sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            irq_en_q <= 1'b0;
            err_q    <= 1'b0;
            cs_q     <= '0;
        end else begin
            if (ctl_we) {irq_en_q, sel_q} <= ctl_wdata;
            err_q <= reject;
            if (accept) cs_q <= bus_cs;
        end
    end

    mmx_setup_bank #(.NUM_CS(NUM_CS)) u_bank (
        .clk(clk), .rst(rst), .we(setup_we), .idx(setup_idx),
        .wdata(setup_wdata), .rd_idx(bus_cs), .rd_setup(cur_setup)
    );

    mmx_seq u_seq (
        .clk(clk), .rst(rst), .start(accept), .req_we(bus_we),
        .req_addr(bus_addr), .req_wdata(bus_wdata), .setup(cur_setup),
        .busy(seq_busy), .done(seq_done), .cs_act(cs_act), .sclk(spi_sclk),
        .d0(spi_d0), .d0_oe(spi_d0_oe), .rx_take(rx_take), .rx_clr(rx_clr),
        .lanes(lanes)
    );

    mmx_rx_gather u_rx (
        .clk(clk), .rst(rst), .clr(rx_clr), .take(rx_take), .lanes(lanes),
        .din(spi_din), .word(bus_rdata)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_csn
        assign spi_cs_n[g] = !(cs_act && (cs_q == CS_W'(g)));
    end

    assign bus_done   = seq_done || err_q;
    assign bus_err    = err_q;
    assign word_irq   = seq_done && irq_en_q;
    assign xlate_owns = sel_q;
endmodule

// File: rtl/mmx_checker.sv
module mmx_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_done,
    input logic              bus_err,
    input logic              word_irq,
    input logic              spi_sclk,
    input logic [NUM_CS-1:0] spi_cs_n
);
    AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (rst)
        $countones(~spi_cs_n) <= 1); // R8

    AST_CS_FREE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        bus_done |-> ((&spi_cs_n) && $past(&spi_cs_n))); // R8

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (&spi_cs_n) |-> !spi_sclk); // R8

    AST_SCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |=> !spi_sclk); // R2

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_done && (&spi_cs_n) && !spi_sclk)); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        word_irq |-> (bus_done && !bus_err)); // R10
endmodule

bind mmflash_xlate mmx_checker #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst(rst), .bus_done(bus_done), .bus_err(bus_err),
    .word_irq(word_irq), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n)
);

// File: tb/mmflash_xlate_test.sv
`timescale 1ns/1ps
module mmflash_xlate_test;
    localparam int NCS = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic        ctl_we = 0;
    logic [1:0]  ctl_wdata = 0;
    logic        setup_we = 0;
    logic [1:0]  setup_idx = 0;
    logic [26:0] setup_wdata = 0;
    logic        bus_req = 0, bus_we = 0;
    logic [1:0]  bus_cs = 0;
    logic [31:0] bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        bus_done, bus_err, word_irq, xlate_owns;
    logic        spi_sclk, spi_d0, spi_d0_oe;
    logic [NCS-1:0] spi_cs_n;
    logic [3:0]  spi_din = 0;

    always #4 clk = ~clk;

    mmflash_xlate #(.NUM_CS(NCS)) uut (.*);

    int n_chk = 0, n_bad = 0;

    logic [15:0]  r_rdata;
    logic         r_err, r_irq, r_csidle, r_got, r_seen, r_csbad, r_oebad;
    int           r_nbits;
    logic [127:0] r_log;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] hdr(input logic [7:0] op, input logic [31:0] a,
                                         input int nab, input int dl);
        logic [127:0] v = {120'd0, op};
        for (int k = nab - 1; k >= 0; k--) v = {v[119:0], a[8*k +: 8]};
        return v << dl;
    endfunction

    task automatic program_cs(input int cs, input logic [26:0] w);
        @(negedge clk);
        setup_we = 1; setup_idx = 2'(cs); setup_wdata = w;
        @(negedge clk);
        setup_we = 0;
    endtask

    task automatic ctl(input logic [1:0] v);
        @(negedge clk);
        ctl_we = 1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 0;
    endtask

    // one access; the bench acts as flash device; flip writes control in the release cycle
    task automatic access(input bit we, input int cs, input logic [31:0] a,
                          input logic [15:0] wd, input int hbits, input int lanes,
                          input logic [15:0] rdval, input bit flip, input bit new_irq);
        logic prev = 0;
        bit flipped = 0;
        @(negedge clk);
        bus_req = 1; bus_we = we; bus_cs = 2'(cs); bus_addr = a; bus_wdata = wd;
        r_got = 0; r_seen = 0; r_csbad = 0; r_oebad = 0; r_nbits = 0; r_log = 0;
        for (int cyc = 0; cyc < 3000 && !r_got; cyc++) begin
            @(negedge clk);
            bus_req = 0; ctl_we = 0;
            if (bus_done) begin
                r_got = 1; r_rdata = bus_rdata; r_err = bus_err;
                r_irq = word_irq; r_csidle = &spi_cs_n;
            end else begin
                for (int k = 0; k < NCS; k++)
                    if (!spi_cs_n[k] && k != cs) r_csbad = 1;
                if (!spi_cs_n[cs]) r_seen = 1;
                if (r_seen && (&spi_cs_n) && flip && !flipped) begin
                    ctl_we = 1; ctl_wdata = {new_irq, 1'b1}; flipped = 1;
                end
                if (spi_sclk && !prev) begin
                    r_log = {r_log[126:0], spi_d0};
                    if (r_nbits < hbits && !spi_d0_oe) r_oebad = 1;
                    if (!we && r_nbits >= hbits) begin
                        int j = r_nbits - hbits;
                        if (lanes == 2)      spi_din = {2'b00, rdval[7-j], rdval[15-j]};
                        else if (lanes == 4) spi_din = rdval[15-4*j -: 4];
                        else                 spi_din = {2'b00, rdval[15-j], 1'b0};
                    end
                    r_nbits++;
                end
                prev = spi_sclk;
            end
        end
        ctl_we = 0;
        spi_din = 0;
        if (!r_got) chk(0, "watchdog: no response", 0, 1);
    endtask

    task automatic judge(input bit we, input int hbits, input int lanes,
                         input logic [127:0] hexp, input logic [15:0] wd,
                         input logic [15:0] rdval, input bit irq_exp, input string rt);
        int beats = we ? 16 : 16 / lanes;
        chk(r_nbits == hbits + beats, "R3 clock count", r_nbits, hbits + beats);
        chk(!r_oebad, "R2 output enable in header", r_oebad, 0);
        if (we) begin
            chk(r_log == ((hexp << 16) | wd), "R7 write stream", r_log, (hexp << 16) | wd);
        end else begin
            chk((r_log >> beats) == hexp, "R2 opcode/address stream", r_log >> beats, hexp);
            chk(r_rdata == rdval, rt, r_rdata, rdval);
        end
        chk(!r_csbad && r_seen && r_csidle, "R8 chip select", {r_csbad, r_seen, r_csidle}, 3'b011);
        chk(!r_err, "R9 no error while owned", r_err, 0);
        chk(r_irq == irq_exp, "R10 interrupt gate", r_irq, irq_exp);
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit cur_irq = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!bus_done && (&spi_cs_n) && !spi_sclk && !xlate_owns && !word_irq,
            "R1 reset outputs", {bus_done, spi_cs_n, spi_sclk, xlate_owns, word_irq},
            {1'b0, 4'hF, 3'b000});

        // R9: refused while engine not owned
        access(0, 1, 32'h00ABCDEF, 0, 32, 1, 0, 0, 0);
        chk(r_got && r_err && !r_irq, "R9 error response", {r_err, r_irq}, 2'b10);
        chk(r_nbits == 0 && !r_seen, "R9 lines quiet", {r_nbits, r_seen}, 0);
        chk(!xlate_owns, "R9 owner output low", xlate_owns, 0);

        ctl(2'b01);
        chk(xlate_owns, "R9 owner output high", xlate_owns, 1);

        // R1 defaults; R11 writing cs3 does not affect cs0/cs1
        program_cs(3, {2'd3, 5'd9, 2'd1, 2'd0, 8'hEE, 8'hDD});
        access(0, 0, 32'h00123456, 0, 32, 1, 16'hBEEF, 0, 0);
        judge(0, 32, 1, hdr(8'h03, 32'h00123456, 3, 0), 0, 16'hBEEF, 0, "R1 R4 R11 default read");
        access(1, 1, 32'h00FEDCBA, 16'hC0DE, 32, 1, 0, 0, 0);
        judge(1, 32, 1, hdr(8'h02, 32'h00FEDCBA, 3, 0), 16'hC0DE, 0, 0, "R1 R11 default write");

        for (int t = 0; t < 128; t++) begin
            int cs = t % 4, abf = (t / 4) % 4, lm = (t / 16) % 4;
            bit we = t[6];
            int dby = (t / 2) % 4, dbi = (t * 7 + 3) % 32;
            logic [7:0] rc = 8'h0B + 8'(t), wc = 8'h80 ^ 8'(t);
            int dl = (dby != 0) ? 8 * dby : dbi;
            int lanes = (lm == 1) ? 2 : (lm == 3) ? 4 : 1;
            int hbits = 8 + 8 * (abf + 1) + dl;
            logic [31:0] a = 32'h13579BDF * (t + 1);
            logic [15:0] rv = 16'hA5C3 ^ (16'(t) * 16'h0907);
            logic [15:0] wd = 16'h3C96 + 16'(t) * 16'h1111;
            bit flip = (t % 8 == 5);
            bit nirq = ((t / 8) % 2 == 0);
            string rt = (lanes == 2) ? "R5 dual read data" :
                        (lanes == 4) ? "R6 quad read data" : "R4 single read data";
            if (t % 32 == 0) begin
                cur_irq = t[5];
                ctl({cur_irq, 1'b1});
            end
            program_cs(cs, {2'(lm), 5'(dbi), 2'(dby), 2'(abf), wc, rc});
            access(we, cs, a, wd, hbits, lanes, rv, flip, nirq);
            judge(we, hbits, lanes, hdr(we ? wc : rc, a, abf + 1, dl), wd, rv,
                  flip ? nirq : cur_irq, rt);
            if (flip) cur_irq = nirq;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule